// File: doc/BRIEF.md
# Paged Effective-Address Unit with Auto-Indexing

This block works out the operand address of a memory-reference instruction on a machine with 12-bit words and 4096 words of memory. Memory is split into 128-word pages. The instruction's 9-bit addressing field carries three things: an offset inside a page, a choice between page zero and the current page, and an indirect flag. A direct reference uses the address built from that field as the effective address.

An indirect reference makes the block read the pointer word at that address through a synchronous memory port, and the pointer then becomes the effective address. Locations 8 to 15 form an auto-increment window. An indirect reference through one of these locations adds one to the pointer (modulo 4096), writes the new value back to the same location, and uses that new value as the effective address.

The caller pulses `start` while the block is idle and then waits for the one-cycle `done` strobe, which comes with `ea`. The block ignores `start` while it is busy.

Top module: `paged_ea_unit`

The sequencer has five states:
- **IDLE** waits for a start request.
- **FETCH** issues the pointer read.
- **LOAD** takes in the read data.
- **STORE** writes back the incremented pointer.
- **FINISH** presents the result.

The transitions are:
- IDLE to FINISH on a direct start.
- IDLE to FETCH on an indirect start.
- FETCH to LOAD.
- LOAD to STORE inside the window, and LOAD to FINISH outside it.
- STORE to FINISH.
- FINISH to IDLE.

## Requirements
- R1: The addressing field is `mref[8:0]`, with bit 8 the indirect flag, bit 7 the page select and bits 6:0 the offset. With the indirect flag at 0 and the page select at 0, `ea` is `{5'b0, offset}` and `done` is high in the first cycle after the accepting edge.
- R2: With the indirect flag at 0 and the page select at 1, `ea` is `{cur_page, offset}`, where `cur_page` is the program counter's upper 5 bits. The latency is the same as in R1.
- R3: With the indirect flag at 1 and the direct address outside 8 to 15, the block asserts `mem_rd` for one cycle at that address in the first cycle after acceptance. It performs no write. `ea` equals the word read, and `done` is high 3 cycles after the accepting edge.
- R4: With the indirect flag at 1 and the direct address inside 8 to 15, the block reads the pointer and then asserts `mem_wr` for one cycle at the same address. The write data is the pointer plus 1 modulo 4096. `ea` equals that incremented value, and `done` is high 4 cycles after the accepting edge.
- R5: A direct reference to addresses 8 to 15 leaves memory unchanged and issues no write.
- R6: `done` lasts exactly one cycle. `busy` is high from the cycle after acceptance through the `done` cycle. `mem_rd` and `mem_wr` are never high together.
- R7: The block ignores a `start` that arrives while `busy` is high. The operation in progress finishes with its own result and latency.
- R8: A synchronous active-high `rst` returns the block to IDLE with `done`, `busy`, `mem_rd` and `mem_wr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; accepted only while idle |
| mref | input | 9 | Addressing field: indirect, page select, offset |
| cur_page | input | 5 | Upper 5 bits of the program counter |
| mem_addr | output | 12 | Memory address |
| mem_rd | output | 1 | Read strobe; data returns the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, one cycle after `mem_rd` |
| ea | output | 12 | Effective address, valid with `done` |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Operation in progress |

## Verification
Each result has a fixed due cycle, counted from the accepting edge:
- `done` and `ea` after 1 cycle for a direct reference.
- After 3 cycles for an indirect reference outside the window.
- After 4 cycles for an indirect reference inside the window.
- The read strobe after 1 cycle, and the write-back after 3 cycles.

The bench drives `start` at a falling edge and counts falling edges until `done`. It compares that count with the latency expected for the reference type. The written-back word and the write count are compared against values computed from the bench's own memory model after `done`.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_STORE,
        ST_FINISH
    } ea_state_e;
endpackage

// File: rtl/ea_direct.sv
module ea_direct #(
    parameter int AW    = 12,
    parameter int OFS_W = 7
) (
    input  logic                 page_sel,
    input  logic [OFS_W-1:0]     offset,
    input  logic [AW-OFS_W-1:0]  cur_page,
    output logic [AW-1:0]        addr
);
    localparam int PW = AW - OFS_W;

    always_comb begin
        addr = {(page_sel ? cur_page : {PW{1'b0}}), offset};
    end
endmodule

// File: rtl/ea_window.sv
module ea_window #(
    parameter int AW = 12,
    parameter int LO = 8,
    parameter int HI = 15
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ptr,
    output logic          hit,
    output logic [AW-1:0] ptr_inc
);
    generate
        if (LO <= HI) begin : g_window
            always_comb hit = (int'(addr) >= LO) && (int'(addr) <= HI);
        end else begin : g_nowindow
            always_comb hit = 1'b0;
        end
    endgenerate

    always_comb ptr_inc = ptr + {{(AW-1){1'b0}}, 1'b1};
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      indirect,
    input  logic      auto_q,
    output ea_state_e state,
    output logic      accept,
    output logic      rd,
    output logic      wr,
    output logic      fin,
    output logic      busy
);
    ea_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = indirect ? ST_FETCH : ST_FINISH;
            ST_FETCH:  nxt = ST_LOAD;
            ST_LOAD:   nxt = auto_q ? ST_STORE : ST_FINISH;
            ST_STORE:  nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = (state == ST_IDLE) && start;
        rd     = (state == ST_FETCH);
        wr     = (state == ST_STORE);
        fin    = (state == ST_FINISH);
        busy   = (state != ST_IDLE);
    end
endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit
    import ea_pkg::*;
#(
    parameter int AW      = 12,
    parameter int OFS_W   = 7,
    parameter int AUTO_LO = 8,
    parameter int AUTO_HI = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [OFS_W+1:0]    mref,
    input  logic [AW-OFS_W-1:0] cur_page,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [AW-1:0]       mem_wdata,
    input  logic [AW-1:0]       mem_rdata,
    output logic [AW-1:0]       ea,
    output logic                done,
    output logic                busy
);
    localparam int IND_BIT = OFS_W + 1;
    localparam int PSL_BIT = OFS_W;

    logic [AW-1:0] dir_addr, ptr_inc, ptr_q, ea_q;
    logic          hit, auto_q, accept, rd, wr, fin, bsy;
    ea_state_e     state;

    ea_direct #(.AW(AW), .OFS_W(OFS_W)) i_direct (
        .page_sel (mref[PSL_BIT]),
        .offset   (mref[OFS_W-1:0]),
        .cur_page (cur_page),
        .addr     (dir_addr)
    );

    ea_window #(.AW(AW), .LO(AUTO_LO), .HI(AUTO_HI)) i_window (
        .addr    (dir_addr),
        .ptr     (mem_rdata),
        .hit     (hit),
        .ptr_inc (ptr_inc)
    );

    ea_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .indirect (mref[IND_BIT]),
        .auto_q   (auto_q),
        .state    (state),
        .accept   (accept),
        .rd       (rd),
        .wr       (wr),
        .fin      (fin),
        .busy     (bsy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            ea_q   <= '0;
            auto_q <= 1'b0;
        end else begin
            if (accept) begin
                ptr_q  <= dir_addr;
                auto_q <= hit;
                if (!mref[IND_BIT]) ea_q <= dir_addr;
            end
            if (state == ST_LOAD) ea_q <= auto_q ? ptr_inc : mem_rdata;
        end
    end

    always_comb begin
        mem_addr  = ptr_q;
        mem_rd    = rd;
        mem_wr    = wr;
        mem_wdata = ea_q;
        ea        = ea_q;
        done      = fin;
        busy      = bsy;
    end
endmodule

// File: rtl/paged_ea_unit_chk.sv
module paged_ea_unit_chk #(
    parameter int AW      = 12,
    parameter int OFS_W   = 7,
    parameter int AUTO_LO = 8,
    parameter int AUTO_HI = 15
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [OFS_W+1:0]    mref,
    input logic [AW-1:0]       mem_addr,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic [AW-1:0]       mem_wdata,
    input logic [AW-1:0]       mem_rdata,
    input logic [AW-1:0]       ea,
    input logic                done,
    input logic                busy
);
    // R1
    direct_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !mref[OFS_W+1]) |=> done);

    // R4
    wb_value_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == AW'($past(mem_rdata) + 1'b1)));

    // R4
    wb_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (int'(mem_addr) >= AUTO_LO && int'(mem_addr) <= AUTO_HI && $past(mem_rd, 2)));

    // R4
    wb_ea_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(mem_wr)) |-> (ea == $past(mem_wdata)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

bind paged_ea_unit paged_ea_unit_chk #(
    .AW(AW), .OFS_W(OFS_W), .AUTO_LO(AUTO_LO), .AUTO_HI(AUTO_HI)
) i_chk (
    .clk(clk), .rst(rst), .start(start), .mref(mref),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ea(ea), .done(done), .busy(busy)
);

// File: tb/test_paged_ea_unit.sv
module test_paged_ea_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  mref = '0;
    logic [4:0]  cur_page = '0;
    logic [11:0] mem_addr, mem_wdata, ea;
    logic [11:0] mem_rdata = '0;
    logic        mem_rd, mem_wr, done, busy;

    logic [11:0] mem [4096];
    int total = 0, bad = 0, cycles = 0, wr_count = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    paged_ea_unit i_paged_ea_unit (
        .clk(clk), .rst(rst), .start(start), .mref(mref), .cur_page(cur_page),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ea(ea), .done(done), .busy(busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic logic [11:0] dir_of(input logic [8:0] m, input logic [4:0] pg);
        return {(m[7] ? pg : 5'd0), m[6:0]};
    endfunction

    // Runs one operation; when hold is set, start stays high with altered fields while busy (R7).
    task automatic run_op(input logic [8:0] m, input logic [4:0] pg, input bit hold);
        logic [11:0] da, ptr, exp_ea;
        int exp_lat, lat, w0;
        bit win;
        da  = dir_of(m, pg);
        win = (da >= 12'd8) && (da <= 12'd15);
        ptr = mem[da];
        if (!m[8]) begin
            exp_ea = da; exp_lat = 1;
        end else if (win) begin
            exp_ea = ptr + 12'd1; exp_lat = 4;
        end else begin
            exp_ea = ptr; exp_lat = 3;
        end
        @(negedge clk);
        mref = m; cur_page = pg; start = 1'b1;
        w0 = wr_count;
        @(negedge clk);
        lat = 1;
        if (hold) begin
            mref = ~m; cur_page = ~pg;
        end else start = 1'b0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (!m[8]) begin
            check(m[7] ? "R2 ea" : "R1 ea", ea, exp_ea);
            check(m[7] ? "R2 latency" : "R1 latency", lat, exp_lat);
            check("R5 no write", wr_count - w0, 0);
            check("R5 memory kept", mem[da], ptr);
        end else if (win) begin
            check("R4 ea", ea, exp_ea);
            check("R4 latency", lat, exp_lat);
            check("R4 writes", wr_count - w0, 1);
            check("R4 stored", mem[da], exp_ea);
        end else begin
            check("R3 ea", ea, exp_ea);
            check("R3 latency", lat, exp_lat);
            check("R3 no write", wr_count - w0, 0);
        end
        if (hold) check("R7 latency", lat, exp_lat);
        check("R6 busy at done", busy, 1);
        @(negedge clk);
        check("R6 done pulse", done, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = 12'($urandom);
        mem[9] = 12'hFFF;
        repeat (3) @(negedge clk);
        check("R8 done after reset", done, 0);
        check("R8 busy after reset", busy, 0);
        check("R8 strobes after reset", mem_rd | mem_wr, 0);
        rst = 1'b0;

        run_op(9'b0_0_0000101, 5'd19, 1'b0);   // R1 page zero
        run_op(9'b0_1_1111111, 5'd31, 1'b0);   // R2 current page top
        run_op(9'b0_0_0001010, 5'd3,  1'b0);   // R5 direct into window
        run_op(9'b1_0_0001001, 5'd7,  1'b0);   // R4 wrap 0xFFF -> 0
        run_op(9'b1_0_0001000, 5'd2,  1'b0);   // R4 low edge
        run_op(9'b1_0_0001111, 5'd2,  1'b0);   // R4 high edge
        run_op(9'b1_0_0000111, 5'd2,  1'b0);   // R3 just below window
        run_op(9'b1_0_0010000, 5'd2,  1'b0);   // R3 just above window
        run_op(9'b1_1_0001000, 5'd6,  1'b0);   // R3 current page, offset 8
        run_op(9'b1_0_0001100, 5'd0,  1'b1);   // R7 start held while busy
        run_op(9'b1_1_0100000, 5'd9,  1'b1);   // R7

        for (int k = 0; k < 150; k++) begin
            logic [8:0] m;
            m = 9'($urandom);
            if ($urandom % 3 == 0) m = {1'b1, 1'b0, 4'b0001, 3'($urandom)};
            run_op(m, 5'($urandom), ($urandom % 5) == 0);
        end

        // R8: reset in the middle of an auto-increment operation
        @(negedge clk);
        mref = 9'b1_0_0001011; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-op done", done, 0);
        check("R8 mid-op busy", busy, 0);
        check("R8 mid-op strobes", mem_rd | mem_wr, 0);
        rst = 1'b0;
        run_op(9'b0_1_0000001, 5'd4, 1'b0);   // R2 after reset

        finished = 1'b1;
    end

    initial begin
        wait (finished || cycles > 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule